// File: doc/BRIEF.md
# Microcode-Driven Address Walker with Single-Slot Rewind

This block produces one memory address per clock for a microcoded controller that streams data from feature and weight memories. Each cycle a microword supplies three control fields: a load flag, a rewind flag and one value field. The value field is either an absolute address or a signed-agnostic step that is added to the running address. Sums wrap modulo 2^AW.

A single backup slot acts as a toggle. A rewind request while the slot is empty records the current address, and the walker still advances by the step in that cycle. The next rewind request jumps back to the recorded address and empties the slot. With this, a microprogram can emit overlapping windows such as 1,2,3,4,2,3,4,5 without a separate counter. An empty slot is marked by the value zero. So recording address 0 leaves the slot empty, and the next request records again.

Top module: `addr_walker`

## Requirements
- R1: While `rst_n` is low, `addr` is 0 and the backup slot is emptied, so the first rewind request after reset records rather than restores.
- R2: A high `purge` at a clock edge sets `addr` to 0 and empties the slot. It overrides `load` and `rewind` in the same cycle.
- R3: With `load` high, `addr` takes the value of `value` at the next edge.
- R4: With `load` and `rewind` both low, `addr` becomes `addr + value` modulo 2^AW at the next edge. For example, 0xFFFE plus 3 gives 0x0001.
- R5: With `rewind` high, `load` low and the slot empty (zero), the slot records the current `addr`, and `addr` advances by `value` as in R4.
- R6: With `rewind` high, `load` low and the slot nonzero, `addr` takes the recorded value and the slot is emptied.
- R7: When `load` and `rewind` are both high, only the load happens and the slot keeps its contents.
- R8: Recording while `addr` is 0 leaves the slot empty, so the following rewind request records again instead of restoring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| purge | input | 1 | Synchronous clear of address and slot |
| load | input | 1 | Microword flag: load `value` as the address |
| rewind | input | 1 | Microword flag: record or restore via the slot |
| value | input | AW | Microword field: absolute address or step |
| addr | output | AW | Current address |

## Verification
The bench steps through microprograms for a linear run, a strided run, the 1,2,3,4,2,3,4,5 window and a wrap past the top of the address space.

- A design that let `load` consult the slot would restore or empty it on a combined request. The restore that follows would then land on the wrong address.
- A record taken at address 0 is followed by a second request. A design that tracked fullness with a separate flag would restore 0 there instead of recording.
- A design that failed to clear the slot on reset or purge would jump back to a stale address on the first request afterwards. The bench checks this after both reset and purge.

// File: rtl/addr_walker.sv
module addr_walker #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          purge,
  input  logic          load,
  input  logic          rewind,
  input  logic [AW-1:0] value,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ZERO = '0;

  logic [AW-1:0] cur_q, slot_q;
  logic [AW-1:0] cur_d, slot_d;
  logic [AW-1:0] stepped;
  logic          slot_full;

  assign stepped   = cur_q + value;
  assign slot_full = (slot_q != ZERO);
  assign addr      = cur_q;

  always_comb begin
    cur_d  = stepped;
    slot_d = slot_q;
    if (purge) begin
      cur_d  = ZERO;
      slot_d = ZERO;
    end else if (load) begin
      cur_d = value;
    end else if (rewind) begin
      if (slot_full) begin
        cur_d  = slot_q;
        slot_d = ZERO;
      end else begin
        slot_d = cur_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= ZERO;
      slot_q <= ZERO;
    end else begin
      cur_q  <= cur_d;
      slot_q <= slot_d;
    end
  end

  p_purge_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> (addr == ZERO) && (slot_q == ZERO));

  p_load_takes_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!purge && load) |=> addr == $past(value));

  p_step_adds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!purge && !load && !rewind) |=> addr == AW'($past(addr) + $past(value)));

  p_record_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!purge && !load && rewind && slot_q == ZERO)
      |=> (slot_q == $past(addr)) && (addr == AW'($past(addr) + $past(value))));

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!purge && !load && rewind && slot_q != ZERO)
      |=> (addr == $past(slot_q)) && (slot_q == ZERO));

  p_load_keeps_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!purge && load) |=> $stable(slot_q));

endmodule

// File: tb/sim_addr_walker.sv
module sim_addr_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        purge = 1'b0, load = 1'b0, rewind = 1'b0;
  logic [15:0] value = '0;
  logic [15:0] addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  addr_walker #(.AW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .purge(purge), .load(load),
    .rewind(rewind), .value(value), .addr(addr)
  );

  // {req[3:0], purge, load, rewind, value[15:0], expected addr[15:0]}
  localparam int N = 25;
  localparam logic [38:0] VEC [N] = '{
    {4'd3, 3'b010, 16'h0001, 16'h0001}, // R3 load 1
    {4'd4, 3'b000, 16'h0001, 16'h0002}, // R4 step
    {4'd5, 3'b001, 16'h0001, 16'h0003}, // R5 record 2, advance
    {4'd4, 3'b000, 16'h0001, 16'h0004},
    {4'd6, 3'b001, 16'h0001, 16'h0002}, // R6 restore 2
    {4'd4, 3'b000, 16'h0001, 16'h0003},
    {4'd4, 3'b000, 16'h0001, 16'h0004},
    {4'd4, 3'b000, 16'h0001, 16'h0005},
    {4'd3, 3'b010, 16'h000A, 16'h000A},
    {4'd4, 3'b000, 16'h0002, 16'h000C}, // R4 stride 2
    {4'd4, 3'b000, 16'h0002, 16'h000E},
    {4'd4, 3'b000, 16'h0002, 16'h0010},
    {4'd3, 3'b010, 16'hFFFE, 16'hFFFE},
    {4'd4, 3'b000, 16'h0003, 16'h0001}, // R4 wrap
    {4'd7, 3'b011, 16'h0100, 16'h0100}, // R7 load wins, slot stays empty
    {4'd5, 3'b001, 16'h0000, 16'h0100}, // R5 record 0x100
    {4'd7, 3'b011, 16'h0200, 16'h0200}, // R7 load wins, slot kept
    {4'd7, 3'b001, 16'h0005, 16'h0100}, // R7 slot survived -> restore
    {4'd6, 3'b001, 16'h0001, 16'h0101}, // R6 slot emptied -> records
    {4'd2, 3'b100, 16'h1234, 16'h0000}, // R2 purge
    {4'd8, 3'b001, 16'h0007, 16'h0007}, // R8 record at 0 (slot still empty)
    {4'd8, 3'b001, 16'h0001, 16'h0008}, // R8 records again (7)
    {4'd4, 3'b000, 16'h0001, 16'h0009},
    {4'd6, 3'b001, 16'h0001, 16'h0007}, // R6 restore 7
    {4'd2, 3'b111, 16'h4321, 16'h0000}  // R2 purge overrides all
  };

  task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: addr=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic p, input logic l, input logic r, input logic [15:0] v);
    @(negedge clk);
    purge = p; load = l; rewind = r; value = v;
    @(negedge clk);
    purge = 1'b0; load = 1'b0; rewind = 1'b0; value = '0;
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #35;
    check(1, addr, 16'h0000); // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      {purge, load, rewind} = VEC[i][34:32];
      value = VEC[i][31:16];
      @(negedge clk);
      check(int'(VEC[i][38:35]), addr, VEC[i][15:0]);
      purge = 1'b0; load = 1'b0; rewind = 1'b0; value = '0;
    end

    // R1: reset mid-run empties the slot
    step(1'b0, 1'b1, 1'b0, 16'h0055);
    step(1'b0, 1'b0, 1'b1, 16'h0000);   // records 0x55
    check(5, addr, 16'h0055);
    #3 rst_n = 1'b0;
    #2 check(1, addr, 16'h0000);        // R1 asynchronous clear
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1, 16'h0003);   // must record, not restore 0x55
    check(1, addr, 16'h0003);
    step(1'b0, 1'b0, 1'b1, 16'h0000);   // restores 0 recorded after reset? slot holds 0 -> records 3
    check(8, addr, 16'h0003);
    step(1'b0, 1'b0, 1'b1, 16'h0009);   // slot holds 3 -> restore
    check(6, addr, 16'h0003);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule